// File: doc/BRIEF.md
# I2C Configuration Register Port

This block is an I2C target that lets an external controller read and write a bank of 142 eight-bit configuration registers. Addressing works the way it does on a small serial EEPROM. In a write transfer, the first byte after the device address loads an internal register pointer, and every byte after that is stored at the pointer. A read transfer returns bytes starting at the current pointer, so a random read is a pointer-only write followed by a repeated start and the read address.

SCL and SDA are sampled by the system clock through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. SDA is driven open-drain: the block only ever pulls the line low.

Register 1 bit 0 is a run control bit. It can be set by a write and stays set until reset. Registers 121 to 131 are plain storage. The whole bank is presented on a flat output bus so the surrounding logic can use it.

Top module: `i2c_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, `switch_run` is 0 and `sda_oe` is 0 (SDA released).
- R2: The block acknowledges the address byte 0xBE (7-bit address 0x5F with R/W=0, write) and 0xBF (R/W=1, read). Any other address byte is not acknowledged: SDA stays released on the ninth clock, and the bytes that follow up to the next START are ignored.
- R3: In a write transfer, the byte after the address loads the pointer. Each byte after that is written at the pointer. The block acknowledges the address, the pointer and every data byte by holding SDA low on the ninth clock.
- R4: The pointer advances by one after each data byte that is written or read, and it wraps from 141 to 0.
- R5: In a read transfer the block shifts out the byte at the pointer MSB first, then releases SDA on the ninth clock. A controller ACK (SDA low) continues with the next register. A controller NACK ends the transfer with SDA released.
- R6: Writing 1 to register 1 bit 0 sets `switch_run`. Later writes of 0 to that bit leave it at 1, and only reset clears it. Bits 7..1 of register 1 are written normally.
- R7: A pointer byte of 142 or more loads the pointer with 0.
- R8: `sda_oe` changes only while SCL is low.
- R9: A START seen anywhere, including part-way through a byte, restarts address reception. A STOP returns the block to idle with SDA released. A byte cut off this way is not written.
- R10: Registers 121 to 131 store and return written data like any other register.
- R11: A read transfer that is not preceded by a pointer write (current-address read) starts at the pointer left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | NREG*8 (1136) | All registers, register k at bits [8k+7:8k] |
| switch_run | output | 1 | Sticky run bit, register 1 bit 0 |

## Verification
The bench goes after the pointer wrap from 141 to 0, in both a burst write and a sequential read. A design that wraps late or not at all would write past the bank or return the wrong register. It writes the run bit to 1 and then to 0 while changing the upper bits of register 1. A design that treats the bit as ordinary storage would drop `switch_run`, and one that masks the whole register would lose bits 7..1. It also sends a foreign address, a pointer beyond the map, and a START inside a data byte. A design that handles any of these loosely would acknowledge the wrong address, store data at a wild index, or commit a half-received byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDAT,
        PH_ACK,
        PH_RDAT,
        PH_RACK
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_cfg_cond.sv
module i2c_cfg_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_s;

    prev_s prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    assign start_det =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_det  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
    import i2c_cfg_pkg::*;
#(
    parameter int         NREG = 142,
    parameter int         PW   = 8,
    parameter logic [6:0] DEV7 = 7'h5F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [PW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [PW-1:0] ptr,
    output logic          busy
);
    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    typedef struct packed {
        phase_e       ph;
        phase_e       after;
        logic [3:0]   cnt;
        logic [7:0]   sh;
        logic [PW-1:0] ptr;
        logic         oe;
        logic         more;
    } eng_s;

    eng_s st_d, st_q;
    logic [PW-1:0] ptr_inc;

    always_comb begin
        ptr_inc = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.ptr;
        wr_data = st_q.sh;

        if (stop_det) begin
            st_d.ph = PH_IDLE;
            st_d.oe = 1'b0;
        end else if (start_det) begin
            st_d.ph  = PH_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else begin
            unique case (st_q.ph)
                PH_ADDR, PH_PTR, PH_WDAT: begin
                    if (scl_rise && st_q.cnt < 4'd8) begin
                        st_d.sh  = {st_q.sh[6:0], sda_s};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == 4'd8) begin
                        st_d.cnt = '0;
                        if (st_q.ph == PH_ADDR) begin
                            if (st_q.sh[7:1] == DEV7) begin
                                st_d.oe    = 1'b1;
                                st_d.ph    = PH_ACK;
                                st_d.after = st_q.sh[0] ? PH_RDAT : PH_PTR;
                            end else begin
                                st_d.ph = PH_IDLE;
                            end
                        end else if (st_q.ph == PH_PTR) begin
                            st_d.ptr   = (int'(st_q.sh) < NREG) ? PW'(st_q.sh) : '0;
                            st_d.oe    = 1'b1;
                            st_d.ph    = PH_ACK;
                            st_d.after = PH_WDAT;
                        end else begin
                            wr_en      = 1'b1;
                            st_d.ptr   = ptr_inc;
                            st_d.oe    = 1'b1;
                            st_d.ph    = PH_ACK;
                            st_d.after = PH_WDAT;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.ph  = st_q.after;
                        st_d.cnt = '0;
                        st_d.oe  = 1'b0;
                        if (st_q.after == PH_RDAT) begin
                            st_d.sh = rd_data;
                            st_d.oe = ~rd_data[7];
                        end
                    end
                end
                PH_RDAT: begin
                    if (scl_fall) begin
                        if (st_q.cnt == 4'd7) begin
                            st_d.oe  = 1'b0;
                            st_d.ph  = PH_RACK;
                            st_d.ptr = ptr_inc;
                            st_d.cnt = '0;
                        end else begin
                            st_d.sh  = {st_q.sh[6:0], 1'b0};
                            st_d.oe  = ~st_q.sh[6];
                            st_d.cnt = st_q.cnt + 4'd1;
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        st_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.more) begin
                            st_d.ph  = PH_RDAT;
                            st_d.sh  = rd_data;
                            st_d.oe  = ~rd_data[7];
                            st_d.cnt = '0;
                        end else begin
                            st_d.ph = PH_IDLE;
                        end
                    end
                end
                default: begin
                    st_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, after: PH_IDLE, cnt: '0, sh: '0,
                      ptr: '0, oe: 1'b0, more: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe = st_q.oe;
    assign ptr    = st_q.ptr;
    assign busy   = (st_q.ph != PH_IDLE);
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
    parameter int NREG    = 142,
    parameter int PW      = 8,
    parameter int RUN_REG = 1,
    parameter int RUN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [PW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] flat,
    output logic              run
);
    localparam logic [7:0] STICKY = 8'(1 << RUN_BIT);

    logic [7:0] cells [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_cell
            logic [7:0] cell_d, cell_q;
            logic       hit;

            assign hit = wr_en && (wr_addr == PW'(i));

            if (i == RUN_REG) begin : g_sticky
                always_comb begin
                    cell_d = cell_q;
                    if (hit) cell_d = wr_data | (cell_q & STICKY);
                end
            end else begin : g_plain
                always_comb begin
                    cell_d = cell_q;
                    if (hit) cell_d = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cell_q <= '0;
                else        cell_q <= cell_d;
            end

            assign cells[i]      = cell_q;
            assign flat[i*8 +: 8] = cell_q;
        end
    endgenerate

    assign rd_data = cells[rd_addr];
    assign run     = cells[RUN_REG][RUN_BIT];
endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port #(
    parameter int         NREG        = 142,
    parameter logic [6:0] DEV7        = 7'h5F,
    parameter int         RUN_REG     = 1,
    parameter int         RUN_BIT     = 0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs,
    output logic              switch_run
);
    localparam int PW = $clog2(NREG);

    logic          scl_s, sda_s;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en, busy;
    logic [PW-1:0] wr_addr, ptr;
    logic [7:0]    wr_data, rd_data;

    i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
    );

    i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
    );

    i2c_cfg_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_engine #(.NREG(NREG), .PW(PW), .DEV7(DEV7)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr(ptr), .busy(busy)
    );

    i2c_cfg_bank #(.NREG(NREG), .PW(PW), .RUN_REG(RUN_REG), .RUN_BIT(RUN_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data),
        .flat(cfg_regs), .run(switch_run)
    );
endmodule

// File: rtl/i2c_cfg_port_chk.sv
module i2c_cfg_port_chk #(
    parameter int NREG    = 142,
    parameter int PW      = 8,
    parameter int RUN_REG = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              busy,
    input logic              wr_en,
    input logic [PW-1:0]     wr_addr,
    input logic [7:0]        wr_data,
    input logic [PW-1:0]     ptr,
    input logic [NREG*8-1:0] cfg_regs,
    input logic              switch_run
);
    logic [PW+2:0] wbase;
    assign wbase = {wr_addr, 3'b000};

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) != RUN_REG)) |=> (cfg_regs[$past(wbase) +: 8] == $past(wr_data)));

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(switch_run) |-> switch_run);

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < NREG);

    // R2
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);
endmodule

bind i2c_cfg_port i2c_cfg_port_chk #(.NREG(NREG), .PW(PW), .RUN_REG(RUN_REG)) u_chk (.*);

// File: tb/i2c_cfg_port_test.sv
module i2c_cfg_port_test;
    localparam int NREG = 142;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, switch_run;
    logic [NREG*8-1:0] cfg_regs;
    wire  sda_line = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    i2c_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs), .switch_run(switch_run)
    );

    // {pointer, written byte, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'd5,   8'h3C, 8'h3C},
        {8'd1,   8'h00, 8'h00},
        {8'd1,   8'hA1, 8'hA1},
        {8'd1,   8'h40, 8'h41},
        {8'd121, 8'h77, 8'h77},
        {8'd131, 8'h88, 8'h88},
        {8'd141, 8'hE5, 8'hE5},
        {8'd0,   8'h5A, 8'h5A}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return cfg_regs[k*8 +: 8];
    endfunction

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(nack, s);
    endtask

    task automatic wr1(input logic [7:0] p, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start;
        send_byte(8'hBE, a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop;
        chk("R2 write address ack", {31'd0, a0}, 32'd1);
        chk("R3 pointer and data ack", {30'd0, a1, a2}, 32'd3);
    endtask

    task automatic rd_random(input logic [7:0] p, output logic [7:0] v);
        logic a0, a1, a2;
        bus_start;
        send_byte(8'hBE, a0);
        send_byte(p, a1);
        bus_start;
        send_byte(8'hBF, a2);
        recv_byte(1'b1, v);
        bus_stop;
        chk("R5 random read acks", {29'd0, a0, a1, a2}, 32'd7);
    endtask

    initial begin
        logic       a, a1, a2;
        logic [7:0] v;
        tick(10);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
        chk("R1 run bit clear", {31'd0, switch_run}, 32'd0);
        chk("R1 bank zero", {31'd0, |cfg_regs}, 32'd0);

        // Vector table: write then random read (R3, R6, R10)
        for (int k = 0; k < 8; k++) begin
            wr1(VEC[k][23:16], VEC[k][15:8]);
            rd_random(VEC[k][23:16], v);
            chk("R3 R10 read back", {24'd0, v}, {24'd0, VEC[k][7:0]});
        end
        chk("R6 run stays set", {31'd0, switch_run}, 32'd1);
        chk("R6 upper bits written", {24'd0, reg_at(1)}, 32'h41);
        chk("R10 window reg 121", {24'd0, reg_at(121)}, 32'h77);

        // R2 foreign address is ignored
        bus_start;
        send_byte(8'hA0, a);
        send_byte(8'h05, a1);
        send_byte(8'hFF, a2);
        bus_stop;
        chk("R2 foreign address not acked", {31'd0, a}, 32'd0);
        chk("R2 foreign data ignored", {24'd0, reg_at(5)}, 32'h3C);
        chk("R2 sda released", {31'd0, sda_oe}, 32'd0);

        // R4 burst write wraps 141 -> 0
        bus_start;
        send_byte(8'hBE, a);
        send_byte(8'd139, a);
        send_byte(8'h9C, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop;
        chk("R4 burst 139", {24'd0, reg_at(139)}, 32'h9C);
        chk("R4 burst 140", {24'd0, reg_at(140)}, 32'h11);
        chk("R4 burst 141", {24'd0, reg_at(141)}, 32'h22);
        chk("R4 burst wrap 0", {24'd0, reg_at(0)}, 32'h33);

        // R11 current-address read after a pointer-only write, R5 sequential read
        bus_start;
        send_byte(8'hBE, a);
        send_byte(8'd139, a);
        bus_stop;
        bus_start;
        send_byte(8'hBF, a);
        chk("R2 read address ack", {31'd0, a}, 32'd1);
        recv_byte(1'b0, v); chk("R11 first byte at pointer", {24'd0, v}, 32'h9C);
        recv_byte(1'b0, v); chk("R5 sequential 140", {24'd0, v}, 32'h11);
        recv_byte(1'b0, v); chk("R5 sequential 141", {24'd0, v}, 32'h22);
        recv_byte(1'b1, v); chk("R4 read wrap to 0", {24'd0, v}, 32'h33);
        chk("R5 released after nack", {31'd0, sda_oe}, 32'd0);
        bus_stop;

        // R7 out-of-map pointer loads 0
        wr1(8'd200, 8'h6B);
        chk("R7 pointer 200 lands at 0", {24'd0, reg_at(0)}, 32'h6B);
        chk("R7 reg 141 untouched", {24'd0, reg_at(141)}, 32'h22);

        // R9 START inside a data byte aborts it
        bus_start;
        send_byte(8'hBE, a);
        send_byte(8'd20, a);
        bit_xfer(1'b1, a1);
        bit_xfer(1'b0, a1);
        bit_xfer(1'b1, a1);
        bit_xfer(1'b0, a1);
        bus_start;
        send_byte(8'hBE, a);
        chk("R9 restart acked", {31'd0, a}, 32'd1);
        send_byte(8'd21, a);
        send_byte(8'h44, a);
        bus_stop;
        chk("R9 partial byte dropped", {24'd0, reg_at(20)}, 32'h00);
        chk("R9 write after restart", {24'd0, reg_at(21)}, 32'h44);
        chk("R9 idle after stop", {31'd0, sda_oe}, 32'd0);

        // R6 clearing attempt on the run bit
        wr1(8'd1, 8'h00);
        chk("R6 run bit sticky", {31'd0, switch_run}, 32'd1);
        chk("R6 reg1 after zero write", {24'd0, reg_at(1)}, 32'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule